// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block passes 9-bit words from a write clock domain to an independent read clock domain. Words go into a RAM of 2^AW slots. The read and write pointers cross between the domains as Gray codes through two-flop synchronisers. Each domain raises its own level flags. The write side drives full, half-full and almost-full. The read side drives empty and almost-empty. A flag asserts at once on the edge of its own clock. It releases only after the other domain's pointer has crossed over.

A mode bit picks one of two read behaviours. In standard mode, a read request loads the next word into the output register. In first-word-fall-through mode, the output register prefetches the oldest word without a request, and that word still counts as stored. The usable capacity in that mode is therefore one word more than the RAM. The mode bit, the almost-full offset and the almost-empty offset are captured while reset is held. After that they stay fixed.

Top module: `dcfifo_pflag`

## Requirements
- R1: With D = 2^AW, capacity is D words in standard mode and D+1 words in fall-through mode. full_o is 1 exactly when the stored count equals the capacity. A write while full_o is 1 stores nothing.
- R2: Words leave in the order they were written. A read request while empty_o is 1 removes nothing and does not change later output data.
- R3: In standard mode (fwft_i = 0), a read accepted on a read-clock edge presents its word on rdata_o from that edge onward.
- R4: In fall-through mode (fwft_i = 1), the oldest stored word appears on rdata_o with no read request. A read request on a read-clock edge consumes it.
- R5: Once settled, paf_o is 1 exactly when the stored count is at least capacity − m, where m is the latched paf_off_i.
- R6: Once settled, pae_o is 1 exactly when the stored count is at most n in standard mode, or at most n+1 in fall-through mode, where n is the latched pae_off_i.
- R7: Once settled, half_o is 1 exactly when the stored count is at least D/2+1 in standard mode, or at least (D−1)/2+2 in fall-through mode.
- R8: empty_o is 1 exactly when the stored count is 0. In fall-through mode this means no word is held on rdata_o.
- R9: While rst_ni is 0, empty_o and pae_o are 1 and full_o, paf_o and half_o are 0. fwft_i, paf_off_i and pae_off_i are captured on clock edges while rst_ni is 0. Changing them after reset has no effect.
- R10: After a write takes the count above the almost-empty level, pae_o stays 1 at the next read-clock edge and falls within 2 to 6 read-clock edges. After a read takes the count below the almost-full level, paf_o falls within 2 to 6 write-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwft_i | input | 1 | Mode: 0 standard, 1 fall-through; captured in reset |
| paf_off_i | input | AW+1 | Almost-full offset m; captured in reset |
| pae_off_i | input | AW+1 | Almost-empty offset n; captured in reset |
| wen_i | input | 1 | Write enable, sampled on wclk_i rise |
| wdata_i | input | DW | Write data |
| ren_i | input | 1 | Read enable, sampled on rclk_i rise |
| rdata_o | output | DW | Read data register |
| full_o | output | 1 | No room left (write domain) |
| paf_o | output | 1 | Almost full (write domain) |
| half_o | output | 1 | Half full or more (write domain) |
| empty_o | output | 1 | Nothing stored (read domain) |
| pae_o | output | 1 | Almost empty (read domain) |

## Verification
Each flag changes at the edge of its own clock when its own port acts. When the other port acts, the change needs one source-clock cycle for the Gray register, then two destination cycles in the synchroniser, then one flag register. For a pointer moving the other way, that is about four destination edges. The level sweep therefore waits ten cycles after every single write or read before it compares all five flags with values computed from the bench's own count. Two checks are made at the exact edge. Read data is sampled at the falling edge after the read edge in standard mode, and before the read in fall-through mode. For R10, the bench counts edges one at a time and checks both the hold at the first edge and the latest permitted release.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  function automatic int capacity(int depth, logic fwft);
    return fwft ? depth + 1 : depth;
  endfunction

  function automatic int half_level(int depth, logic fwft);
    return fwft ? (depth - 1) / 2 + 2 : depth / 2 + 1;
  endfunction

  function automatic int pae_level(int off, logic fwft);
    return fwft ? off + 1 : off;
  endfunction

endpackage

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem_q [Depth];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/dcfifo_gray_cross.sv
module dcfifo_gray_cross #(
  parameter int W = 5
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_q, sync1_q, sync2_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= bin_i ^ (bin_i >> 1);
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= gray_q;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    logic [W-1:0] b;
    b[W-1] = sync2_q[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ sync2_q[i];
    bin_o = b;
  end

  AST_GRAY_ONE_STEP: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R2

endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
  import dcfifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        wclk_i,
  input  logic        rst_ni,
  input  logic        wen_i,
  input  logic        fwft_i,
  input  logic [AW:0] paf_off_i,
  input  logic [AW:0] rptr_s_i,
  input  logic [AW:0] uptr_s_i,
  output logic [AW:0] wptr_o,
  output logic        we_o,
  output logic        full_o,
  output logic        paf_o,
  output logic        half_o
);
  localparam int PW = AW + 1;
  localparam int Depth = 1 << AW;
  localparam logic [AW:0] DepthP = PW'(Depth);

  logic [AW:0] wptr_q, wptr_n, ram_n, lvl_n;
  logic        full_q, paf_q, half_q;

  assign we_o   = wen_i && !full_q;
  assign wptr_n = wptr_q + PW'(we_o);
  assign ram_n  = wptr_n - rptr_s_i;
  assign lvl_n  = wptr_n - uptr_s_i;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      full_q <= 1'b0;
      paf_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      wptr_q <= wptr_n;
      full_q <= ram_n == DepthP;
      paf_q  <= int'(lvl_n) >= capacity(Depth, fwft_i) - int'(paf_off_i);
      half_q <= int'(lvl_n) >= half_level(Depth, fwft_i);
    end
  end

  assign wptr_o = wptr_q;
  assign full_o = full_q;
  assign paf_o  = paf_q;
  assign half_o = half_q;

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wptr_q - rptr_s_i) <= DepthP); // R1

  AST_FULL_IS_HALF: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_q |-> half_q); // R7

endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
  import dcfifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        rclk_i,
  input  logic        rst_ni,
  input  logic        ren_i,
  input  logic        fwft_i,
  input  logic [AW:0] pae_off_i,
  input  logic [AW:0] wptr_s_i,
  output logic [AW:0] rptr_o,
  output logic [AW:0] uptr_o,
  output logic        load_o,
  output logic        empty_o,
  output logic        pae_o
);
  localparam int PW = AW + 1;

  logic [AW:0] rptr_q, rptr_n, uptr_q, uptr_n, lvl_n;
  logic        ov_q, ov_n, ram_ne, user_rd, load;
  logic        empty_q, pae_q, empty_n;

  assign ram_ne = wptr_s_i != rptr_q;

  always_comb begin
    if (fwft_i == MODE_FWFT) begin
      user_rd = ren_i && ov_q;
      load    = ram_ne && (!ov_q || ren_i);
      ov_n    = load || (ov_q && !user_rd);
      rptr_n  = rptr_q + PW'(load);
      uptr_n  = uptr_q + PW'(user_rd);
      empty_n = !ov_n;
    end else begin
      user_rd = ren_i && ram_ne;
      load    = user_rd;
      ov_n    = 1'b0;
      rptr_n  = rptr_q + PW'(load);
      uptr_n  = rptr_n;
      empty_n = wptr_s_i == rptr_n;
    end
  end

  assign lvl_n = wptr_s_i - uptr_n;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      uptr_q  <= '0;
      ov_q    <= 1'b0;
      empty_q <= 1'b1;
      pae_q   <= 1'b1;
    end else begin
      rptr_q  <= rptr_n;
      uptr_q  <= uptr_n;
      ov_q    <= ov_n;
      empty_q <= empty_n;
      pae_q   <= int'(lvl_n) <= pae_level(int'(pae_off_i), fwft_i);
    end
  end

  assign rptr_o  = rptr_q;
  assign uptr_o  = uptr_q;
  assign load_o  = load;
  assign empty_o = empty_q;
  assign pae_o   = pae_q;

  AST_HELD_WORD_COUNTED: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rptr_q - uptr_q) <= PW'(1)); // R4

  AST_EMPTY_IS_PAE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_q |-> pae_q); // R8

  AST_EMPTY_NO_TAKE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (wptr_s_i == rptr_q) |=> (rptr_q == $past(rptr_q))); // R2

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic [AW:0]   paf_off_i,
  input  logic [AW:0]   pae_off_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          paf_o,
  output logic          half_o,
  output logic          empty_o,
  output logic          pae_o
);
  localparam int PW = AW + 1;
  localparam int NRd = 2; // RAM pointer and consumed-word pointer

  logic          w_fwft, r_fwft;
  logic [AW:0]   w_paf_off, r_pae_off;
  logic [AW:0]   wptr, wptr_s;
  logic [AW:0]   rd_ptr [NRd];
  logic [AW:0]   rd_ptr_s [NRd];
  logic          we, load;
  logic [DW-1:0] ram_rdata, rdata_q;

  // configuration captured only while reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) begin
      w_fwft    <= fwft_i;
      w_paf_off <= paf_off_i;
    end
  end

  always_ff @(posedge rclk_i) begin
    if (!rst_ni) begin
      r_fwft    <= fwft_i;
      r_pae_off <= pae_off_i;
    end
  end

  dcfifo_ram #(.DW(DW), .AW(AW)) i_ram (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (wptr[AW-1:0]),
    .wdata_i (wdata_i),
    .raddr_i (rd_ptr[0][AW-1:0]),
    .rdata_o (ram_rdata)
  );

  dcfifo_wr_side #(.AW(AW)) i_wr (
    .wclk_i    (wclk_i),
    .rst_ni    (rst_ni),
    .wen_i     (wen_i),
    .fwft_i    (w_fwft),
    .paf_off_i (w_paf_off),
    .rptr_s_i  (rd_ptr_s[0]),
    .uptr_s_i  (rd_ptr_s[1]),
    .wptr_o    (wptr),
    .we_o      (we),
    .full_o    (full_o),
    .paf_o     (paf_o),
    .half_o    (half_o)
  );

  dcfifo_rd_side #(.AW(AW)) i_rd (
    .rclk_i    (rclk_i),
    .rst_ni    (rst_ni),
    .ren_i     (ren_i),
    .fwft_i    (r_fwft),
    .pae_off_i (r_pae_off),
    .wptr_s_i  (wptr_s),
    .rptr_o    (rd_ptr[0]),
    .uptr_o    (rd_ptr[1]),
    .load_o    (load),
    .empty_o   (empty_o),
    .pae_o     (pae_o)
  );

  dcfifo_gray_cross #(.W(PW)) i_w2r (
    .src_clk_i (wclk_i),
    .dst_clk_i (rclk_i),
    .rst_ni    (rst_ni),
    .bin_i     (wptr),
    .bin_o     (wptr_s)
  );

  for (genvar g = 0; g < NRd; g++) begin : g_r2w
    dcfifo_gray_cross #(.W(PW)) i_r2w (
      .src_clk_i (rclk_i),
      .dst_clk_i (wclk_i),
      .rst_ni    (rst_ni),
      .bin_i     (rd_ptr[g]),
      .bin_o     (rd_ptr_s[g])
    );
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (load) rdata_q <= ram_rdata;
  end

  assign rdata_o = rdata_q;

endmodule

// File: tb/test_dcfifo_pflag.sv
`timescale 1ns/1ps
module test_dcfifo_pflag;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          fwft = 1'b0, wen = 1'b0, ren = 1'b0;
  logic [AW:0]   paf_off = '0, pae_off = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          full, paf, half, empty, pae;

  int checks = 0, errors = 0;
  int level = 0, wcnt = 0, rcnt = 0;

  always #2.5 wclk = ~wclk;
  initial begin #1.7; forever #2.5 rclk = ~rclk; end

  dcfifo_pflag #(.DW(DW), .AW(AW)) i_dcfifo_pflag (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft),
    .paf_off_i(paf_off), .pae_off_i(pae_off), .wen_i(wen), .wdata_i(wdata),
    .ren_i(ren), .rdata_o(rdata), .full_o(full), .paf_o(paf), .half_o(half),
    .empty_o(empty), .pae_o(pae)
  );

  function automatic logic [DW-1:0] pat(int k);
    return DW'((k * 37 + 11) % 512);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (level %0d)", req, act, exp, level);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge wclk);
  endtask

  task automatic do_reset(logic mode, int m, int n);
    rst_n = 1'b0; fwft = mode; paf_off = (AW+1)'(m); pae_off = (AW+1)'(n);
    repeat (4) @(negedge wclk);
    chk("R9 empty in reset", int'(empty), 1);
    chk("R9 pae in reset", int'(pae), 1);
    chk("R9 full/paf/half in reset", int'({full, paf, half}), 0);
    rst_n = 1'b1;
    @(negedge wclk);
    fwft = ~mode; paf_off = (AW+1)'(m + 5); pae_off = (AW+1)'(n + 6); // R9: must be ignored
    level = 0; wcnt = 0; rcnt = 0;
  endtask

  task automatic wr_one();
    @(negedge wclk); wen = 1'b1; wdata = pat(wcnt);
    @(negedge wclk); wen = 1'b0;
  endtask

  task automatic check_flags(logic mode, int m, int n);
    int cap;
    int hl;
    cap = mode ? D + 1 : D;
    hl  = mode ? (D - 1) / 2 + 2 : D / 2 + 1;
    chk("R1 full", int'(full), int'(level == cap));
    chk("R8 empty", int'(empty), int'(level == 0));
    chk("R5 paf", int'(paf), int'(level >= cap - m));
    chk("R6 pae", int'(pae), int'(level <= (mode ? n + 1 : n)));
    chk("R7 half", int'(half), int'(level >= hl));
  endtask

  task automatic rd_one(logic mode);
    if (mode) begin
      chk("R4 fall-through data", int'(rdata), int'(pat(rcnt)));
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
    end else begin
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
      chk("R3 standard read data", int'(rdata), int'(pat(rcnt)));
    end
    rcnt++; level--;
  endtask

  task automatic sweep(logic mode, int m, int n);
    int cap;
    cap = mode ? D + 1 : D;
    do_reset(mode, m, n);
    settle(); check_flags(mode, m, n);
    for (int k = 0; k < cap; k++) begin
      wr_one(); wcnt++; level++;
      settle(); check_flags(mode, m, n);
    end
    // R1: write while full must be dropped
    @(negedge wclk); wen = 1'b1; wdata = 9'h1AA;
    @(negedge wclk); wen = 1'b0;
    settle(); check_flags(mode, m, n);
    for (int k = 0; k < cap; k++) begin
      rd_one(mode);
      settle(); check_flags(mode, m, n);
    end
    // R2: read while empty removes nothing
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
    settle(); check_flags(mode, m, n);
    wr_one(); wcnt++; level++;
    settle(); check_flags(mode, m, n);
    rd_one(mode);
    settle();
    chk("R2 order after empty read", int'(rdata), int'(pat(wcnt - 1)));
    check_flags(mode, m, n);
  endtask

  task automatic latency_test();
    int edges;
    // pae release after a write (R10)
    do_reset(1'b0, 3, 2);
    wr_one(); wcnt++; wr_one(); wcnt++; level = 2;
    settle();
    chk("R10 pae before write", int'(pae), 1);
    @(negedge wclk); wen = 1'b1; wdata = pat(wcnt);
    @(posedge wclk); wcnt++; level++;
    @(negedge wclk); wen = 1'b0;
    @(posedge rclk); @(negedge rclk);
    chk("R10 pae held one read edge", int'(pae), 1);
    edges = 1;
    while (pae && edges < 10) begin @(posedge rclk); @(negedge rclk); edges++; end
    chk("R10 pae released in window", int'(edges >= 2 && edges <= 6), 1);
    // paf release after a read (R10)
    while (level < D - 3) begin wr_one(); wcnt++; level++; end
    settle();
    chk("R10 paf before read", int'(paf), 1);
    @(negedge rclk); ren = 1'b1;
    @(posedge rclk); level--;
    @(negedge rclk); ren = 1'b0;
    @(posedge wclk); @(negedge wclk);
    edges = 1;
    while (paf && edges < 10) begin @(posedge wclk); @(negedge wclk); edges++; end
    chk("R10 paf released in window", int'(edges >= 2 && edges <= 6), 1);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sweep(1'b0, 3, 2);
    sweep(1'b0, 0, 0);
    sweep(1'b1, 3, 2);
    sweep(1'b1, 1, 5);
    latency_test();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule